// File: doc/BRIEF.md
# Complementary Dead-Time Gate Generator

This block takes a single pulse-width-modulated command and produces two non-overlapping gate-drive commands, one for a main power switch and one for an auxiliary switch such as an active-clamp or synchronous-rectifier device. Each hand-over between the two switches passes through a dead time. The delay before the main switch turns on and the delay before the auxiliary switch turns on are set separately, in clock cycles.

Either dead time can end early through a zero-voltage sense strobe. The strobe lets a switch close as soon as the voltage across it has collapsed. With the enable input low, the block sleeps: it pulls the main command low and releases the auxiliary pin.

A static mode input selects the auxiliary pin polarity. The pin can drive an inverted (P-channel) switch or an N-channel switch that is the true complement of the main switch. The block is fully synchronous. The PWM and sense inputs each pass through a two-flop synchronizer. With a 100 MHz clock, delay counts of 5 to 50 cover 50 ns to 500 ns, and a 1 MHz PWM period spans 100 cycles.

Top module: `cdt_gate_gen`

## Requirements
- R1: A PWM change driven just before clock edge 0 is acted on at edge 2. After a rising change, the auxiliary switch is off from edge 2, and the main switch turns on at edge 2+`on_dly` (a count of 0 acts as 1).
- R2: After a falling PWM change, the main switch is off from edge 2, and the auxiliary switch turns on at edge 2+`off_dly`.
- R3: If `zvs_on` is high while the main-switch dead time runs, that dead time ends. The main switch turns on at the third clock edge after `zvs_on` rises.
- R4: If `zvs_off` is high while the auxiliary-switch dead time runs, that dead time ends. The auxiliary switch turns on at the third clock edge after `zvs_off` rises.
- R5: A sense strobe has no effect while its own dead time is not running. Neither switch changes state.
- R6: A falling PWM edge during the main-switch dead time cancels it, so the main switch never turns on. The auxiliary-switch dead time then counts from that falling edge.
- R7: A rising PWM edge during the auxiliary-switch dead time cancels it, so the auxiliary switch stays off. The main-switch dead time then counts from that rising edge.
- R8: The main and auxiliary switches are never on in the same cycle.
- R9: With `enable` low at a clock edge, the block sleeps from that edge on. In sleep `main_drv` = 0, `aux_oe` = 0 and `aux_drv` = 0, whatever PWM does.
- R10: On waking, both switches are off. Neither switch turns on until a PWM edge occurs after the wake, even if PWM is already high.
- R11: With `aux_inv` = 1, `aux_drv` is low while the auxiliary switch is on and high while it is off. With `aux_inv` = 0, `aux_drv` is high exactly while the auxiliary switch is on.
- R12: While `rst_n` is low, `main_drv` = 0 and `aux_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM command, asynchronous |
| enable | input | 1 | High to run, low to sleep |
| on_dly | input | DLY_W | Dead time before the main switch turns on, in cycles |
| off_dly | input | DLY_W | Dead time before the auxiliary switch turns on, in cycles |
| zvs_on | input | 1 | Zero-voltage strobe that ends the main-switch dead time, asynchronous |
| zvs_off | input | 1 | Zero-voltage strobe that ends the auxiliary-switch dead time, asynchronous |
| aux_inv | input | 1 | Auxiliary pin polarity: 1 inverted, 0 complementary |
| main_drv | output | 1 | Main switch command, high = on |
| aux_drv | output | 1 | Auxiliary pin level |
| aux_oe | output | 1 | Auxiliary pin drive enable; 0 models high impedance |

## Verification
The bench checks each dead time to the exact cycle, on both sides of expiry. An off-by-one counter, or a count that starts from the raw input rather than the synchronized edge, would move the switch-on by one cycle and fail. It cuts each dead time short with its own strobe, and pulses the opposite strobe while that timer is idle. A design that shares sense paths between timers, or that honours a strobe outside its window, would switch on a device at the wrong time. It reverses PWM partway through each dead time. A design that lets the stale timer finish would close the cancelled switch and could turn on both devices together. It also wakes the block with PWM already high, which catches a design that treats the sleep release as a rising edge.

// File: rtl/cdt_gate_gen.sv
module cdt_gate_gen #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             enable,
  input  logic [DLY_W-1:0] on_dly,
  input  logic [DLY_W-1:0] off_dly,
  input  logic             zvs_on,
  input  logic             zvs_off,
  input  logic             aux_inv,
  output logic             main_drv,
  output logic             aux_drv,
  output logic             aux_oe
);

  logic [2:0] pwm_sh;
  logic [1:0] zon_sh, zoff_sh;
  logic       rise, fall, zon, zoff;

  logic             t1_run, t2_run;
  logic [DLY_W-1:0] t1_cnt, t2_cnt;
  logic             main_q, aux_q, asleep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_sh  <= '0;
      zon_sh  <= '0;
      zoff_sh <= '0;
    end else begin
      pwm_sh  <= {pwm_sh[1:0], pwm_in};
      zon_sh  <= {zon_sh[0], zvs_on};
      zoff_sh <= {zoff_sh[0], zvs_off};
    end
  end

  assign rise = pwm_sh[1] & ~pwm_sh[2];
  assign fall = ~pwm_sh[1] & pwm_sh[2];
  assign zon  = zon_sh[1];
  assign zoff = zoff_sh[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q <= 1'b1;
      main_q   <= 1'b0;
      aux_q    <= 1'b0;
      t1_run   <= 1'b0;
      t2_run   <= 1'b0;
      t1_cnt   <= '0;
      t2_cnt   <= '0;
    end else if (!enable) begin
      asleep_q <= 1'b1;
      main_q   <= 1'b0;
      aux_q    <= 1'b0;
      t1_run   <= 1'b0;
      t2_run   <= 1'b0;
    end else if (asleep_q) begin
      asleep_q <= 1'b0;
    end else if (rise) begin
      aux_q  <= 1'b0;
      main_q <= 1'b0;
      t2_run <= 1'b0;
      t1_run <= 1'b1;
      t1_cnt <= DLY_W'(1);
    end else if (fall) begin
      main_q <= 1'b0;
      aux_q  <= 1'b0;
      t1_run <= 1'b0;
      t2_run <= 1'b1;
      t2_cnt <= DLY_W'(1);
    end else begin
      if (t1_run) begin
        if (zon || t1_cnt >= on_dly) begin
          t1_run <= 1'b0;
          main_q <= 1'b1;
        end else begin
          t1_cnt <= t1_cnt + 1'b1;
        end
      end
      if (t2_run) begin
        if (zoff || t2_cnt >= off_dly) begin
          t2_run <= 1'b0;
          aux_q  <= 1'b1;
        end else begin
          t2_cnt <= t2_cnt + 1'b1;
        end
      end
    end
  end

  assign main_drv = main_q;
  assign aux_oe   = ~asleep_q;
  assign aux_drv  = asleep_q ? 1'b0 : (aux_inv ? ~aux_q : aux_q);

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_q && aux_q));

  // R8
  one_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(t1_run && t2_run));

  // R9
  sleep_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!main_drv && !aux_oe));

  // R1
  rise_aux_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && enable) |=> !aux_q);

  // R2
  fall_main_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && enable) |=> !main_q);

  // R1
  main_from_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_q) |-> $past(t1_run));

  // R2
  aux_from_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_q) |-> $past(t2_run));

endmodule

// File: tb/test_cdt_gate_gen.sv
module test_cdt_gate_gen;
  localparam int DLY_W = 8;

  logic clk = 1'b0;
  logic rst_n, pwm_in, enable, zvs_on, zvs_off, aux_inv;
  logic [DLY_W-1:0] on_dly, off_dly;
  logic main_drv, aux_drv, aux_oe;

  int n_chk = 0, n_fail = 0, overlap = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cdt_gate_gen #(.DLY_W(DLY_W)) i_cdt_gate_gen (
    .clk, .rst_n, .pwm_in, .enable, .on_dly, .off_dly,
    .zvs_on, .zvs_off, .aux_inv, .main_drv, .aux_drv, .aux_oe);

  function automatic logic aux_sw();
    return aux_oe && (aux_inv ? ~aux_drv : aux_drv);
  endfunction

  always @(negedge clk) if (rst_n && main_drv && aux_sw()) overlap++;

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // R1: rising change; aux off from n3, main on exactly at n(3+d)
  task automatic t_rise(int d);
    on_dly = DLY_W'(d);
    pwm_in = 1'b1;
    step(3);
    chk("R1 aux off", aux_sw(), 1'b0);
    for (int i = 0; i < d - 1; i++) begin
      chk("R1 main waits", main_drv, 1'b0);
      step(1);
    end
    chk("R1 main before expiry", main_drv, 1'b0);
    step(1);
    chk("R1 main on", main_drv, 1'b1);
  endtask

  // R2: falling change; main off from n3, aux on exactly at n(3+d)
  task automatic t_fall(int d);
    off_dly = DLY_W'(d);
    pwm_in = 1'b0;
    step(3);
    chk("R2 main off", main_drv, 1'b0);
    for (int i = 0; i < d - 1; i++) begin
      chk("R2 aux waits", aux_sw(), 1'b0);
      step(1);
    end
    chk("R2 aux before expiry", aux_sw(), 1'b0);
    step(1);
    chk("R2 aux on", aux_sw(), 1'b1);
  endtask

  task automatic t_zvs_on();
    on_dly = 8'd40;
    pwm_in = 1'b1;
    step(5);
    zvs_on = 1'b1;
    step(2);
    chk("R3 main before strobe lands", main_drv, 1'b0);
    step(1);
    chk("R3 main on early", main_drv, 1'b1);
    zvs_on = 1'b0;
    zvs_off = 1'b1;
    step(6);
    chk("R5 zvs_off idle, main held", main_drv, 1'b1);
    chk("R5 zvs_off idle, aux held", aux_sw(), 1'b0);
    zvs_off = 1'b0;
    step(3);
  endtask

  task automatic t_zvs_off();
    off_dly = 8'd40;
    pwm_in = 1'b0;
    step(5);
    zvs_off = 1'b1;
    step(2);
    chk("R4 aux before strobe lands", aux_sw(), 1'b0);
    step(1);
    chk("R4 aux on early", aux_sw(), 1'b1);
    zvs_off = 1'b0;
    zvs_on = 1'b1;
    step(6);
    chk("R5 zvs_on idle, main held", main_drv, 1'b0);
    chk("R5 zvs_on idle, aux held", aux_sw(), 1'b1);
    zvs_on = 1'b0;
    step(3);
  endtask

  task automatic t_cancel_t1();
    on_dly = 8'd20;
    pwm_in = 1'b1;
    step(8);
    for (int i = 0; i < 2; i++) chk("R6 main off in T1", main_drv, 1'b0);
    pwm_in = 1'b0;
    off_dly = 8'd6;
    for (int i = 0; i < 30; i++) begin
      step(1);
      chk("R6 main never on", main_drv, 1'b0);
      if (i == 7) chk("R6 aux before T2 ends", aux_sw(), 1'b0);
      if (i == 8) chk("R6 aux on from fall", aux_sw(), 1'b1);
    end
  endtask

  task automatic t_cancel_t2();
    pwm_in = 1'b1;
    on_dly = 8'd5;
    step(10);
    off_dly = 8'd30;
    pwm_in = 1'b0;
    step(6);
    pwm_in = 1'b1;
    on_dly = 8'd6;
    for (int i = 0; i < 40; i++) begin
      step(1);
      chk("R7 aux stays off", aux_sw(), 1'b0);
      if (i == 7) chk("R7 main before T1 ends", main_drv, 1'b0);
      if (i == 8) chk("R7 main on from rise", main_drv, 1'b1);
    end
  endtask

  task automatic t_sleep_wake();
    enable = 1'b0;
    step(1);
    chk("R9 main low", main_drv, 1'b0);
    chk("R9 aux released", aux_oe, 1'b0);
    chk("R9 aux pin low", aux_drv, 1'b0);
    for (int i = 0; i < 4; i++) begin
      pwm_in = ~pwm_in;
      step(4);
      chk("R9 main low under pwm", main_drv, 1'b0);
      chk("R9 aux released under pwm", aux_oe, 1'b0);
    end
    pwm_in = 1'b1;
    step(5);
    enable = 1'b1;
    step(1);
    chk("R10 aux driven after wake", aux_oe, 1'b1);
    for (int i = 0; i < 20; i++) begin
      step(1);
      chk("R10 main off until edge", main_drv, 1'b0);
      chk("R10 aux off until edge", aux_sw(), 1'b0);
    end
    t_fall(9);
  endtask

  task automatic t_polarity();
    aux_inv = 1'b1;
    step(1);
    chk("R11 inverted pin low when aux on", aux_drv, 1'b0);
    t_rise(7);
    chk("R11 inverted pin high when aux off", aux_drv, 1'b1);
    t_fall(5);
    chk("R11 inverted pin low again", aux_drv, 1'b0);
    aux_inv = 1'b0;
    step(1);
    chk("R11 complementary pin high when aux on", aux_drv, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; pwm_in = 1'b0;
    zvs_on = 1'b0; zvs_off = 1'b0; aux_inv = 1'b0;
    on_dly = 8'd5; off_dly = 8'd7;
    step(3);
    chk("R12 main in reset", main_drv, 1'b0);
    chk("R12 aux_oe in reset", aux_oe, 1'b0);
    rst_n = 1'b1;
    enable = 1'b1;
    step(4);
    chk("R10 idle main off", main_drv, 1'b0);
    chk("R10 idle aux off", aux_sw(), 1'b0);
    t_rise(5);
    t_fall(7);
    t_rise(12);
    t_fall(1);
    t_zvs_on();
    t_zvs_off();
    t_cancel_t1();
    t_cancel_t2();
    t_sleep_wake();
    t_polarity();
    chk("R8 no overlap seen", overlap == 0, 1'b1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        step(200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule